// File: doc/BRIEF.md
# Partitionable Set-Associative Tag Lookup

This block holds the tag and valid state for an 8-way set-associative on-chip array and answers one request per clock. A request carries a 36-bit physical address and one of four kinds: cache lookup, cache fill, invalidate, or a directly addressed SRAM access. One clock after the request, the block reports hit or miss, the chosen way, and the bank, set and byte fields that the data array needs.

Some of the ways can be set aside as memory-mapped SRAM. A configuration input picks how many ways, and the reserved ways are always the highest-numbered ones. Cache lookups, invalidates and fill victim choice skip the reserved ways. An SRAM access takes its way number from address bits and does no tag compare. Fill victims come from the lowest-numbered free way that is not reserved. When every such way is valid, a per-set round-robin pointer chooses the victim.

A small controller has two states. `ST_IDLE` means no response is pending. `ST_RESP` means a response is presented this cycle. The transitions are:
- `ST_IDLE` → `ST_RESP` when a request arrives.
- `ST_RESP` → `ST_RESP` on back-to-back requests.
- `ST_RESP` → `ST_IDLE` when no request arrives.

Top module: `partition_tag_lookup`

## Requirements
- R1: Address bits are numbered 0 (MSB, `req_addr[35]`) to 35 (LSB, `req_addr[0]`). The fields are:
  - tag = bits 0–20 (`req_addr[35:15]`)
  - bank = bits 21–22 (`req_addr[14:13]`)
  - set = bits 23–30 (`req_addr[12:5]`)
  - byte = bits 31–35 (`req_addr[4:0]`)

  Bank and set together pick the line, and the response echoes bank, set and byte.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. Requests may come back to back, and a request sees every write made by earlier requests.
- R3: For a cache lookup (`req_kind`=0), `rsp_hit`=1 only when a non-reserved way of the line is valid and holds the request tag. `rsp_way` is then the lowest such way. On a miss, `rsp_way`=0.
- R4: `sram_mode` sets the number of reserved ways as follows: 0→0, 1→1, 2→2, 3→4, 4→8, and 5–7→0. The reserved ways are the highest-numbered ones. A reserved way never produces a cache hit, even when it is valid with a matching tag.
- R5: For an SRAM access (`req_kind`=3) with N>0 reserved ways, the raw way number is address bits 18–20 (`req_addr[17:15]`). Its upper bits are forced to 1 so the way lands in the reserved range. The response is `rsp_hit`=1 and `rsp_way`=8−N+(raw mod N). With N=0, the response is `rsp_hit`=0 and `rsp_way`=raw.
- R6: A cache fill (`req_kind`=1) whose tag is absent writes the tag and sets valid in one clock. It picks the lowest-numbered invalid non-reserved way, and reports `rsp_hit`=0 with `rsp_way` set to that way.
- R7: If every non-reserved way of the line is valid, a fill uses the line's round-robin pointer as the victim. A pointer that points at a reserved way is taken as way 0. After each allocating fill, the pointer moves to the way after the victim, wrapping to 0 past the last non-reserved way.
- R8: A fill whose tag already sits valid in a non-reserved way rewrites that way. It reports `rsp_hit`=1 and `rsp_way` set to that way, and leaves the pointer unchanged.
- R9: An invalidate (`req_kind`=2) clears the valid bit of the matching non-reserved way and reports `rsp_hit`=1 with that way. Without a match it changes nothing and reports `rsp_hit`=0 with `rsp_way`=0.
- R10: With all 8 ways reserved, lookups, fills and invalidates all report `rsp_hit`=0 with `rsp_way`=0. Fills and invalidates then write nothing.
- R11: Reset clears every valid bit and every pointer, and holds `rsp_valid` low.
- R12: The byte field takes no part in a lookup. Addresses that differ only in the byte field give the same hit and way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 lookup, 1 fill, 2 invalidate, 3 SRAM access |
| req_addr | input | 36 | Physical address, bit 0 is `req_addr[35]` |
| sram_mode | input | 3 | Encoded count of reserved ways |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Hit (or SRAM way granted) |
| rsp_way | output | 3 | Selected way |
| rsp_bank | output | 2 | Bank field of the request |
| rsp_set | output | 8 | Set field of the request |
| rsp_byte | output | 5 | Byte field of the request |

## Verification
The stimulus first fills one line until it is full, so the free-way rule can be told apart from the round-robin rule. It then refills, invalidates and refills the same tags, which separates refresh, clearing and reuse of the freed way. Lookups that change only the bank, only the set or only the byte field show which address bits take part in the compare. The same line is then viewed under every reserved-way count, including an unused mode code, with SRAM way numbers that both lie inside and fall outside the reserved range. This shows the masking, the folding and the all-reserved miss. A reset in the middle of the run, followed by a lookup of a filled tag, shows that valid state is cleared.

// File: rtl/tlk_pkg.sv
package tlk_pkg;

    // Request kinds carried on req_kind
    typedef enum logic [1:0] {
        RQ_LOOKUP = 2'd0,
        RQ_FILL   = 2'd1,
        RQ_DROP   = 2'd2,
        RQ_SRAM   = 2'd3
    } req_kind_e;

    // Response controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/tlk_addr_split.sv
module tlk_addr_split #(
    parameter int TAG_W  = 21,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 5,
    parameter int WAY_W  = 3,
    localparam int ADDR_W = TAG_W + BANK_W + IDX_W + OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  set_idx,
    output logic [OFS_W-1:0]  ofs,
    output logic [WAY_W-1:0]  sram_raw
);
    localparam int SET_LO  = OFS_W;
    localparam int BANK_LO = OFS_W + IDX_W;
    localparam int TAG_LO  = BANK_LO + BANK_W;

    // Most significant address bit is numbered 0, so fields read top-down
    assign tag      = addr[ADDR_W-1:TAG_LO];
    assign bank     = addr[TAG_LO-1:BANK_LO];
    assign set_idx  = addr[BANK_LO-1:SET_LO];
    assign ofs      = addr[OFS_W-1:0];
    // SRAM way number: the lowest-order tag bits
    assign sram_raw = addr[TAG_LO+WAY_W-1:TAG_LO];
endmodule

// File: rtl/tlk_tag_store.sv
module tlk_tag_store #(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 21,
    parameter int LINE_W = 10,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LINES = 1 << LINE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINE_W-1:0]          line,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAY_W-1:0]           rd_ptr,
    input  logic                       tag_we,
    input  logic                       vld_clr,
    input  logic                       ptr_we,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [WAY_W-1:0]           ptr_val
);
    logic [WAYS-1:0][TAG_W-1:0] tag_mem [LINES];
    logic [WAYS-1:0]            vld_mem [LINES];
    logic [WAY_W-1:0]           ptr_mem [LINES];

    assign rd_tags  = tag_mem[line];
    assign rd_valid = vld_mem[line];
    assign rd_ptr   = ptr_mem[line];

    // Tag bits need no reset: valid gates every use
    always_ff @(posedge clk) begin
        if (tag_we) begin
            tag_mem[line][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                vld_mem[i] <= '0;
                ptr_mem[i] <= '0;
            end
        end else begin
            if (tag_we) begin
                vld_mem[line][wr_way] <= 1'b1;
            end
            if (vld_clr) begin
                vld_mem[line][wr_way] <= 1'b0;
            end
            if (ptr_we) begin
                ptr_mem[line] <= ptr_val;
            end
        end
    end
endmodule

// File: rtl/tlk_way_pick.sv
module tlk_way_pick #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [WAYS-1:0]            resv_mask,
    input  logic [WAY_W-1:0]           ptr,
    input  logic [WAY_W-1:0]           last_open,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           victim,
    output logic [WAY_W-1:0]           next_ptr
);
    logic [WAYS-1:0] match_vec;
    logic [WAYS-1:0] free_vec;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match_vec[w] = valid[w] && !resv_mask[w] && (tags[w] == req_tag);
            assign free_vec[w]  = !valid[w] && !resv_mask[w];
        end
    endgenerate

    assign hit = |match_vec;

    // Lowest-numbered matching way
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Free way first, otherwise round-robin pointer folded into open range
    always_comb begin
        if (|free_vec) begin
            victim = '0;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (free_vec[w]) victim = WAY_W'(w);
            end
        end else if (ptr > last_open) begin
            victim = '0;
        end else begin
            victim = ptr;
        end
        next_ptr = (victim == last_open) ? '0 : victim + 1'b1;
    end
endmodule

// File: rtl/partition_tag_lookup.sv
module partition_tag_lookup
    import tlk_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 21,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 5,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CNT_W  = WAY_W + 1,
    localparam int MODE_W = $clog2(WAY_W + 2),
    localparam int LINE_W = BANK_W + IDX_W,
    localparam int ADDR_W = TAG_W + BANK_W + IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MODE_W-1:0] sram_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [IDX_W-1:0]  rsp_set,
    output logic [OFS_W-1:0]  rsp_byte
);
    req_kind_e  kind;
    ctl_state_e state_q, state_d;

    logic [TAG_W-1:0]  a_tag;
    logic [BANK_W-1:0] a_bank;
    logic [IDX_W-1:0]  a_set;
    logic [OFS_W-1:0]  a_ofs;
    logic [WAY_W-1:0]  a_raw;

    logic [WAYS-1:0][TAG_W-1:0] rd_tags;
    logic [WAYS-1:0]            rd_valid;
    logic [WAY_W-1:0]           rd_ptr;

    logic [CNT_W-1:0] resv_cnt;
    logic [WAYS-1:0]  resv_mask;
    logic             any_open;
    logic [WAY_W-1:0] last_open;
    logic [WAY_W-1:0] low_mask;
    logic [WAY_W-1:0] sram_way;

    logic             pk_hit;
    logic [WAY_W-1:0] pk_hit_way, pk_victim, pk_next;

    logic             tag_we, vld_clr, ptr_we;
    logic [WAY_W-1:0] wr_way;
    logic             hit_d;
    logic [WAY_W-1:0] way_d;

    assign kind = req_kind_e'(req_kind);

    tlk_addr_split #(
        .TAG_W(TAG_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .WAY_W(WAY_W)
    ) u_split (
        .addr(req_addr), .tag(a_tag), .bank(a_bank), .set_idx(a_set),
        .ofs(a_ofs), .sram_raw(a_raw)
    );

    tlk_tag_store #(
        .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .line({a_bank, a_set}),
        .rd_tags(rd_tags), .rd_valid(rd_valid), .rd_ptr(rd_ptr),
        .tag_we(tag_we), .vld_clr(vld_clr), .ptr_we(ptr_we),
        .wr_way(wr_way), .wr_tag(a_tag), .ptr_val(pk_next)
    );

    // Reserved-way count from the encoded mode: code m gives 2^(m-1)
    always_comb begin
        resv_cnt = '0;
        for (int m = 1; m <= WAY_W + 1; m++) begin
            if (sram_mode == MODE_W'(m)) resv_cnt = CNT_W'(1 << (m - 1));
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_resv
            assign resv_mask[w] = (int'(resv_cnt) + w) >= WAYS;
        end
    endgenerate

    assign any_open  = int'(resv_cnt) < WAYS;
    assign last_open = WAY_W'(WAYS - 1 - int'(resv_cnt));
    assign low_mask  = WAY_W'(int'(resv_cnt) - 1);
    assign sram_way  = (resv_cnt != '0) ? (a_raw | ~low_mask) : a_raw;

    tlk_way_pick #(
        .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_pick (
        .tags(rd_tags), .valid(rd_valid), .req_tag(a_tag), .resv_mask(resv_mask),
        .ptr(rd_ptr), .last_open(last_open),
        .hit(pk_hit), .hit_way(pk_hit_way), .victim(pk_victim), .next_ptr(pk_next)
    );

    // Per-request actions on the store and the next response values
    always_comb begin
        tag_we  = 1'b0;
        vld_clr = 1'b0;
        ptr_we  = 1'b0;
        wr_way  = '0;
        hit_d   = 1'b0;
        way_d   = '0;
        if (req_valid) begin
            unique case (kind)
                RQ_LOOKUP: begin
                    hit_d = pk_hit;
                    way_d = pk_hit ? pk_hit_way : '0;
                end
                RQ_FILL: begin
                    if (pk_hit) begin
                        tag_we = 1'b1;
                        wr_way = pk_hit_way;
                        hit_d  = 1'b1;
                        way_d  = pk_hit_way;
                    end else if (any_open) begin
                        tag_we = 1'b1;
                        ptr_we = 1'b1;
                        wr_way = pk_victim;
                        way_d  = pk_victim;
                    end
                end
                RQ_DROP: begin
                    if (pk_hit) begin
                        vld_clr = 1'b1;
                        wr_way  = pk_hit_way;
                        hit_d   = 1'b1;
                        way_d   = pk_hit_way;
                    end
                end
                RQ_SRAM: begin
                    hit_d = (resv_cnt != '0);
                    way_d = sram_way;
                end
            endcase
        end
    end

    // Controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Controller: registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit  <= 1'b0;
            rsp_way  <= '0;
            rsp_bank <= '0;
            rsp_set  <= '0;
            rsp_byte <= '0;
        end else if (req_valid) begin
            rsp_hit  <= hit_d;
            rsp_way  <= way_d;
            rsp_bank <= a_bank;
            rsp_set  <= a_set;
            rsp_byte <= a_ofs;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/partition_tag_lookup_chk.sv
module partition_tag_lookup_chk #(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 21,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 5,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CNT_W  = WAY_W + 1,
    localparam int MODE_W = $clog2(WAY_W + 2),
    localparam int ADDR_W = TAG_W + BANK_W + IDX_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [MODE_W-1:0] sram_mode,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [IDX_W-1:0]  rsp_set,
    input logic [OFS_W-1:0]  rsp_byte
);
    localparam int TAG_LO = OFS_W + IDX_W + BANK_W;

    logic [CNT_W-1:0] cnt_now, cnt_q;
    logic [1:0]       kind_q;
    logic [WAY_W-1:0] raw_q;

    assign cnt_now = (sram_mode >= 1 && int'(sram_mode) <= WAY_W + 1)
                     ? CNT_W'(1 << (int'(sram_mode) - 1)) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= '0;
            raw_q  <= '0;
        end else if (req_valid) begin
            cnt_q  <= cnt_now;
            kind_q <= req_kind;
            raw_q  <= req_addr[TAG_LO+WAY_W-1:TAG_LO];
        end
    end

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_fields_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_bank == $past(req_addr[TAG_LO-1:TAG_LO-BANK_W]))
                   && (rsp_set  == $past(req_addr[OFS_W+IDX_W-1:OFS_W]))
                   && (rsp_byte == $past(req_addr[OFS_W-1:0])));

    assert_no_reserved_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q == 2'd0 && rsp_hit) |-> (int'(rsp_way) + int'(cnt_q) < WAYS));

    assert_sram_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q == 2'd3 && cnt_q != '0) |->
            rsp_hit && (int'(rsp_way) + int'(cnt_q) >= WAYS)
            && (((rsp_way ^ raw_q) & WAY_W'(int'(cnt_q) - 1)) == '0));

    assert_fill_open_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q == 2'd1 && int'(cnt_q) < WAYS) |-> (int'(rsp_way) + int'(cnt_q) < WAYS));

    assert_all_reserved_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'd3 && int'(cnt_now) == WAYS) |=> !rsp_hit);
endmodule

bind partition_tag_lookup partition_tag_lookup_chk #(
    .WAYS(WAYS), .TAG_W(TAG_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .sram_mode(sram_mode), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_bank(rsp_bank),
    .rsp_set(rsp_set), .rsp_byte(rsp_byte)
);

// File: tb/partition_tag_lookup_bench.sv
module partition_tag_lookup_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] K_LOOK = 2'd0, K_FILL = 2'd1, K_DROP = 2'd2, K_SRAM = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [35:0] req_addr;
    logic [2:0]  sram_mode;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_way;
    logic [1:0]  rsp_bank;
    logic [7:0]  rsp_set;
    logic [4:0]  rsp_byte;

    partition_tag_lookup u_partition_tag_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .sram_mode(sram_mode), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_bank(rsp_bank),
        .rsp_set(rsp_set), .rsp_byte(rsp_byte)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    int unsigned m_tag [1024][8];
    bit          m_val [1024][8];
    int          m_ptr [1024];

    // Expected response for the next sampling point
    bit    e_valid;
    bit    e_hit;
    int    e_way, e_bank, e_set, e_byte;
    string e_req;

    function automatic logic [35:0] mk(int tag, int bank, int set_i, int byt);
        return {21'(tag), 2'(bank), 8'(set_i), 5'(byt)};
    endfunction

    function automatic int resv_of(int mode);
        if (mode >= 1 && mode <= 4) return 1 << (mode - 1);
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_now();
        chk(rsp_valid == e_valid, e_valid ? e_req : "R2", "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid && rsp_valid) begin
            chk(rsp_hit == e_hit, e_req, "rsp_hit", int'(rsp_hit), int'(e_hit));
            chk(int'(rsp_way) == e_way, e_req, "rsp_way", int'(rsp_way), e_way);
            chk(int'(rsp_bank) == e_bank && int'(rsp_set) == e_set && int'(rsp_byte) == e_byte,
                "R1", "fields", {rsp_bank, rsp_set, rsp_byte}, (e_bank << 13) | (e_set << 5) | e_byte);
        end
    endtask

    task automatic model_clear();
        for (int l = 0; l < 1024; l++) begin
            m_ptr[l] = 0;
            for (int w = 0; w < 8; w++) m_val[l][w] = 0;
        end
    endtask

    task automatic model_apply(logic [1:0] k, logic [35:0] a, int mode);
        int line = int'(a[14:5]);
        int tag  = int'(a[35:15]);
        int n    = resv_of(mode);
        int open = 8 - n;
        int hw   = -1;
        int v    = -1;
        for (int w = 0; w < open; w++)
            if (m_val[line][w] && m_tag[line][w] == tag && hw < 0) hw = w;
        e_bank = int'(a[14:13]);
        e_set  = int'(a[12:5]);
        e_byte = int'(a[4:0]);
        e_hit  = 0;
        e_way  = 0;
        case (k)
            K_LOOK: begin
                e_hit = (hw >= 0);
                e_way = (hw >= 0) ? hw : 0;
            end
            K_FILL: begin
                if (hw >= 0) begin
                    e_hit = 1;
                    e_way = hw;
                end else if (open > 0) begin
                    for (int w = 0; w < open; w++) if (!m_val[line][w] && v < 0) v = w;
                    if (v < 0) v = (m_ptr[line] >= open) ? 0 : m_ptr[line];
                    m_tag[line][v] = tag;
                    m_val[line][v] = 1;
                    m_ptr[line] = (v == open - 1) ? 0 : v + 1;
                    e_way = v;
                end
            end
            K_DROP: begin
                if (hw >= 0) begin
                    m_val[line][hw] = 0;
                    e_hit = 1;
                    e_way = hw;
                end
            end
            default: begin
                if (n > 0) begin
                    e_hit = 1;
                    e_way = open + (int'(a[17:15]) % n);
                end else begin
                    e_way = int'(a[17:15]);
                end
            end
        endcase
    endtask

    // One clock: check the outputs, then drive the next request
    task automatic step(bit v, logic [1:0] k, logic [35:0] a, int mode, string req);
        @(negedge clk);
        compare_now();
        req_valid = v;
        req_kind  = k;
        req_addr  = a;
        sram_mode = 3'(mode);
        e_valid   = v;
        e_req     = req;
        if (v) model_apply(k, a, mode);
    endtask

    task automatic idle();
        step(1'b0, K_LOOK, '0, 0, "R2");
    endtask

    initial begin
        int bank_a = 1;
        int set_a  = 8'h3C;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_kind = '0;
        req_addr = '0;
        sram_mode = '0;
        e_valid = 0;
        e_req = "R11";
        model_clear();
        repeat (3) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
        end
        rst_n = 1'b1;

        // Empty line misses
        step(1, K_LOOK, mk(21'h1000, bank_a, set_a, 0), 0, "R3");
        // Fill an empty line: free ways in order
        for (int i = 0; i < 8; i++) step(1, K_FILL, mk(21'h1000 + i, bank_a, set_a, i), 0, "R6");
        idle();
        // Lookups hit their ways, byte field ignored
        for (int i = 0; i < 8; i++) step(1, K_LOOK, mk(21'h1000 + i, bank_a, set_a, 31 - i), 0, "R12");
        // Other bank / other set do not hit
        step(1, K_LOOK, mk(21'h1002, 2, set_a, 0), 0, "R1");
        step(1, K_LOOK, mk(21'h1002, bank_a, set_a + 1, 0), 0, "R1");
        step(1, K_LOOK, mk(21'h1FFF, bank_a, set_a, 0), 0, "R3");
        // Full line: round robin
        step(1, K_FILL, mk(21'h2000, bank_a, set_a, 0), 0, "R7");
        step(1, K_FILL, mk(21'h2001, bank_a, set_a, 0), 0, "R7");
        // Refresh of present tag
        step(1, K_FILL, mk(21'h1004, bank_a, set_a, 0), 0, "R8");
        step(1, K_FILL, mk(21'h2002, bank_a, set_a, 0), 0, "R7");
        // Invalidate, repeat, refill the hole
        step(1, K_DROP, mk(21'h1003, bank_a, set_a, 0), 0, "R9");
        step(1, K_DROP, mk(21'h1003, bank_a, set_a, 0), 0, "R9");
        step(1, K_LOOK, mk(21'h1003, bank_a, set_a, 0), 0, "R9");
        step(1, K_FILL, mk(21'h3000, bank_a, set_a, 0), 0, "R6");
        idle();
        // Four reserved ways: upper ways stop hitting, fills stay low
        step(1, K_LOOK, mk(21'h1005, bank_a, set_a, 0), 3, "R4");
        step(1, K_LOOK, mk(21'h1007, bank_a, set_a, 0), 3, "R4");
        step(1, K_LOOK, mk(21'h2002, bank_a, set_a, 0), 3, "R3");
        step(1, K_DROP, mk(21'h1006, bank_a, set_a, 0), 3, "R4");
        step(1, K_FILL, mk(21'h4000, bank_a, set_a, 0), 3, "R7");
        step(1, K_FILL, mk(21'h4001, bank_a, set_a, 0), 3, "R7");
        step(1, K_FILL, mk(21'h4002, bank_a, set_a, 0), 3, "R7");
        // Mode 0 again: reserved way contents come back
        step(1, K_LOOK, mk(21'h1006, bank_a, set_a, 0), 0, "R4");
        // SRAM accesses across modes and raw way numbers
        for (int m = 0; m < 8; m++)
            for (int r = 0; r < 8; r += 3)
                step(1, K_SRAM, mk(21'h1F0 | r, m % 4, r * 17, r), m, "R5");
        // All ways reserved
        step(1, K_LOOK, mk(21'h4000, bank_a, set_a, 0), 4, "R10");
        step(1, K_FILL, mk(21'h5000, bank_a, set_a, 0), 4, "R10");
        step(1, K_DROP, mk(21'h4001, bank_a, set_a, 0), 4, "R10");
        step(1, K_LOOK, mk(21'h5000, bank_a, set_a, 0), 0, "R10");
        step(1, K_LOOK, mk(21'h4001, bank_a, set_a, 0), 0, "R10");
        // Unused mode code treated as no reservation
        step(1, K_LOOK, mk(21'h1007, bank_a, set_a, 0), 6, "R4");
        idle();
        idle();
        // Mid-run reset clears valid state
        @(negedge clk);
        compare_now();
        req_valid = 1'b0;
        rst_n = 1'b0;
        model_clear();
        e_valid = 0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        step(1, K_LOOK, mk(21'h1007, bank_a, set_a, 0), 0, "R11");
        step(1, K_FILL, mk(21'h6000, bank_a, set_a, 0), 0, "R11");
        idle();
        idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule